// File: doc/BRIEF.md
# Four-Lane Priority Egress Scheduler

This block sits in front of one egress port. Software-built packet descriptors come in one at a time, each with a 3-bit class tag and a length. The scheduler sorts each descriptor into one of four lanes and returns one serialized descriptor stream to the port under a valid/ready handshake. The four lanes are timing/trigger, event metadata, bulk video and logs. The two critical lanes always win arbitration. Bulk video is held back by a token bucket, so a burst of large frames cannot crowd out critical traffic. The log lane is policed by a small count-based bucket.

Each lane holds one pending descriptor. A full critical or bulk lane pushes back on the input instead of discarding. A log descriptor that meets an empty policer bucket is the only kind that is thrown away, and each such discard is counted. The block also reports these values at its ports: accepted descriptors per lane, the worst enqueue-to-grant wait per lane, and descriptors whose tag named no defined class.

Top module: `lane_egress_sched`

## Requirements
- R1: After reset no descriptor is offered, the input is ready, the bulk bucket is empty, the log bucket is full (LOG_DEPTH tokens), and every counter reads zero.
- R2: Tag 0 selects the timing lane, 1 the metadata lane, 2 the bulk lane and 3 the log lane. Tags 4 to 7 go to the log lane, and each accepted descriptor with such a tag adds one to `miscls_count`. `out_lane` uses the same numbering 0 to 3.
- R3: Each lane holds one descriptor. While the lane addressed by the input is occupied, `in_ready` is low for timing, metadata and bulk traffic, so those lanes never lose a descriptor.
- R4: A pending timing descriptor is offered ahead of all others. A pending metadata descriptor is offered ahead of bulk and log.
- R5: The bulk bucket gains `bulk_rate` tokens every cycle and is capped at `bulk_depth`. A bulk descriptor is eligible only while the bucket holds at least its length, and its grant removes that many tokens.
- R6: The log bucket gains one token every LOG_PERIOD cycles, up to LOG_DEPTH, and each stored log descriptor spends one. A log descriptor arriving on an empty bucket is accepted, discarded and added to `log_drops`.
- R7: When an eligible bulk descriptor and a log descriptor are both pending and no critical lane is, the two lanes alternate. Bulk is preferred first after reset.
- R8: `lane_max_lat` holds, per lane, the largest number of clock edges seen between a descriptor's enqueue edge and its grant edge.
- R9: `lane_hits` counts, per lane, the descriptors stored into that lane. Discarded descriptors are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input descriptor valid |
| in_tag | input | 3 | Class tag |
| in_len | input | LEN_W | Descriptor length in token units |
| in_ready | output | 1 | Input descriptor accepted this cycle |
| out_valid | output | 1 | A descriptor is offered |
| out_lane | output | 2 | Lane of the offered descriptor |
| out_len | output | LEN_W | Length of the offered descriptor |
| out_ready | input | 1 | Port takes the offered descriptor |
| bulk_rate | input | TOK_W | Bulk tokens added per cycle |
| bulk_depth | input | TOK_W | Bulk bucket cap |
| lane_hits | output | 4*CNT_W | Stored descriptors per lane, lane 0 in low bits |
| lane_max_lat | output | 4*CNT_W | Worst enqueue-to-grant wait per lane |
| log_drops | output | CNT_W | Log descriptors discarded by the policer |
| miscls_count | output | CNT_W | Descriptors with an undefined tag |

## Verification
Directed sequences come first. A bulk descriptor is parked with a zero refill rate, which shows that the token gate alone holds it back. All four lanes are loaded while the port stalls, so the release order shows strict priority and then the bulk/log alternation. A back-to-back log stream drains the policer bucket and separates back-pressure from discards. An undefined tag shows the log lane fallback. Long random mixes of tags, lengths and port stalls are then checked every cycle against a bench model built from the requirements. These mixes expose token arithmetic errors and latency bookkeeping errors that the short sequences do not reach.

// File: rtl/lane_egress_sched.sv
module lane_egress_sched #(
  parameter int LEN_W      = 12,
  parameter int TOK_W      = 16,
  parameter int CNT_W      = 16,
  parameter int LOG_DEPTH  = 4,
  parameter int LOG_PERIOD = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         in_tag,
  input  logic [LEN_W-1:0]   in_len,
  output logic               in_ready,
  output logic               out_valid,
  output logic [1:0]         out_lane,
  output logic [LEN_W-1:0]   out_len,
  input  logic               out_ready,
  input  logic [TOK_W-1:0]   bulk_rate,
  input  logic [TOK_W-1:0]   bulk_depth,
  output logic [4*CNT_W-1:0] lane_hits,
  output logic [4*CNT_W-1:0] lane_max_lat,
  output logic [CNT_W-1:0]   log_drops,
  output logic [CNT_W-1:0]   miscls_count
);
  localparam int LB_W = $clog2(LOG_DEPTH + 1);
  localparam int DV_W = (LOG_PERIOD > 1) ? $clog2(LOG_PERIOD) : 1;

  logic [3:0]       slot_v;
  logic [LEN_W-1:0] slot_len [4];
  logic [CNT_W-1:0] age [4];
  logic [CNT_W-1:0] max_lat [4];
  logic [CNT_W-1:0] hits [4];
  logic [TOK_W-1:0] bulk_tok;
  logic [LB_W-1:0]  log_tok;
  logic [DV_W-1:0]  div;
  logic             rr;

  wire [1:0] in_lane   = in_tag[2] ? 2'd3 : in_tag[1:0];
  wire       log_empty = (log_tok == '0);
  assign in_ready = ((in_lane == 2'd3) && log_empty) || !slot_v[in_lane];
  wire accept = in_valid && in_ready;
  wire drop   = accept && (in_lane == 2'd3) && log_empty;
  wire store  = accept && !drop;
  wire bulk_ok = slot_v[2] && (bulk_tok >= TOK_W'(slot_len[2]));

  always_comb begin
    out_valid = 1'b1;
    out_lane  = 2'd0;
    if (slot_v[0])                   out_lane = 2'd0;
    else if (slot_v[1])              out_lane = 2'd1;
    else if (bulk_ok && slot_v[3])   out_lane = rr ? 2'd3 : 2'd2;
    else if (bulk_ok)                out_lane = 2'd2;
    else if (slot_v[3])              out_lane = 2'd3;
    else                             out_valid = 1'b0;
  end
  assign out_len = slot_len[out_lane];
  wire fire = out_valid && out_ready;

  wire [TOK_W-1:0] bulk_use = (fire && out_lane == 2'd2) ? TOK_W'(slot_len[2]) : '0;
  wire [TOK_W:0]   tok_sum  = (TOK_W+1)'(bulk_tok) - (TOK_W+1)'(bulk_use) + (TOK_W+1)'(bulk_rate);
  wire [TOK_W-1:0] tok_next = (tok_sum > (TOK_W+1)'(bulk_depth)) ? bulk_depth : tok_sum[TOK_W-1:0];

  wire            tick    = (div == DV_W'(LOG_PERIOD - 1));
  wire            log_use = store && (in_lane == 2'd3);
  wire [LB_W:0]   log_sum = (LB_W+1)'(log_tok) - (LB_W+1)'(log_use) + (LB_W+1)'(tick);
  wire [LB_W-1:0] log_next = (log_sum > (LB_W+1)'(LOG_DEPTH)) ? LB_W'(LOG_DEPTH) : log_sum[LB_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v       <= '0;
      bulk_tok     <= '0;
      log_tok      <= LB_W'(LOG_DEPTH);
      div          <= '0;
      rr           <= 1'b0;
      log_drops    <= '0;
      miscls_count <= '0;
      for (int l = 0; l < 4; l++) begin
        slot_len[l] <= '0;
        age[l]      <= '0;
        max_lat[l]  <= '0;
        hits[l]     <= '0;
      end
    end else begin
      bulk_tok <= tok_next;
      log_tok  <= log_next;
      div      <= tick ? '0 : div + 1'b1;
      if (fire && out_lane == 2'd2) rr <= 1'b1;
      else if (fire && out_lane == 2'd3) rr <= 1'b0;
      if (drop) log_drops <= log_drops + 1'b1;
      if (accept && in_tag[2]) miscls_count <= miscls_count + 1'b1;
      for (int l = 0; l < 4; l++) begin
        if (fire && out_lane == 2'(l)) begin
          slot_v[l] <= 1'b0;
          if (age[l] > max_lat[l]) max_lat[l] <= age[l];
        end else if (store && in_lane == 2'(l)) begin
          slot_v[l]   <= 1'b1;
          slot_len[l] <= in_len;
          age[l]      <= CNT_W'(1);
          hits[l]     <= hits[l] + 1'b1;
        end else if (slot_v[l] && age[l] != '1) begin
          age[l] <= age[l] + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_pack
    assign lane_hits[g*CNT_W +: CNT_W]    = hits[g];
    assign lane_max_lat[g*CNT_W +: CNT_W] = max_lat[g];
  end

  AST_SYNC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_lane == 2'd0) |=> slot_v[0]); // R3
  AST_BULK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_lane == 2'd2) |-> (bulk_tok >= TOK_W'(out_len))); // R5
  AST_TOK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bulk_tok <= $past(bulk_depth))); // R5
  AST_DROP_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (log_drops == CNT_W'($past(log_drops) + 1'b1))); // R6
  AST_MISCLS_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_tag[2]) |=> (miscls_count == CNT_W'($past(miscls_count) + 1'b1))); // R2
  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_lane != 2'd0) |-> !slot_v[0]); // R4
endmodule

// File: tb/lane_egress_sched_test.sv
module lane_egress_sched_test;
  localparam int LEN_W = 12, TOK_W = 16, CNT_W = 16, LD = 4, LP = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [2:0]         in_tag;
  logic [LEN_W-1:0]   in_len, out_len;
  logic [1:0]         out_lane;
  logic [TOK_W-1:0]   bulk_rate, bulk_depth;
  logic [4*CNT_W-1:0] lane_hits, lane_max_lat;
  logic [CNT_W-1:0]   log_drops, miscls_count;

  lane_egress_sched #(.LEN_W(LEN_W), .TOK_W(TOK_W), .CNT_W(CNT_W), .LOG_DEPTH(LD), .LOG_PERIOD(LP)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag), .in_len(in_len),
    .in_ready(in_ready), .out_valid(out_valid), .out_lane(out_lane), .out_len(out_len),
    .out_ready(out_ready), .bulk_rate(bulk_rate), .bulk_depth(bulk_depth),
    .lane_hits(lane_hits), .lane_max_lat(lane_max_lat), .log_drops(log_drops),
    .miscls_count(miscls_count));

  int total = 0, bad = 0;
  bit done = 0;
  bit mv[4];
  int mlen[4], mage[4], mmax[4], mhits[4];
  int mtok, mlog, mdiv, mdrops, mmis, rate, depth;
  bit mrr;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pick();
    bit b;
    if (mv[0]) return 0;
    if (mv[1]) return 1;
    b = mv[2] && (mtok >= mlen[2]);
    if (b && mv[3]) return mrr ? 3 : 2;
    if (b) return 2;
    if (mv[3]) return 3;
    return -1;
  endfunction

  task automatic step(bit iv, int tag, int len, bit ordy);
    int p, il, use_b, nt;
    bit le, rdy, fire, acc, drp, sto, tick;
    in_valid = iv; in_tag = tag[2:0]; in_len = len[LEN_W-1:0]; out_ready = ordy;
    bulk_rate = rate[TOK_W-1:0]; bulk_depth = depth[TOK_W-1:0];
    #1;
    p = pick();
    il = (tag >= 4) ? 3 : tag;
    le = (mlog == 0);
    rdy = (il == 3 && le) || !mv[il];
    chk("R3 in_ready", int'(in_ready), int'(rdy));
    chk("R4 out_valid", int'(out_valid), int'(p >= 0));
    if (p >= 0) begin
      chk("R4/R7 out_lane", int'(out_lane), p);
      chk("R5 out_len", int'(out_len), mlen[p]);
    end
    for (int l = 0; l < 4; l++) begin
      chk("R9 lane_hits", int'(lane_hits[l*CNT_W +: CNT_W]), mhits[l]);
      chk("R8 lane_max_lat", int'(lane_max_lat[l*CNT_W +: CNT_W]), mmax[l]);
    end
    chk("R6 log_drops", int'(log_drops), mdrops);
    chk("R2 miscls_count", int'(miscls_count), mmis);
    fire = (p >= 0) && ordy;
    acc = iv && rdy;
    drp = acc && il == 3 && le;
    sto = acc && !drp;
    use_b = (fire && p == 2) ? mlen[2] : 0;
    for (int l = 0; l < 4; l++) begin
      if (fire && p == l) begin
        mv[l] = 0;
        if (mage[l] > mmax[l]) mmax[l] = mage[l];
      end else if (sto && il == l) begin
        mv[l] = 1; mlen[l] = len; mage[l] = 1; mhits[l]++;
      end else if (mv[l]) mage[l]++;
    end
    nt = mtok - use_b + rate;
    mtok = (nt > depth) ? depth : nt;
    tick = (mdiv == LP - 1);
    mdiv = tick ? 0 : mdiv + 1;
    mlog = mlog - int'(sto && il == 3) + int'(tick);
    if (mlog > LD) mlog = LD;
    if (drp) mdrops++;
    if (acc && tag >= 4) mmis++;
    if (fire && p == 2) mrr = 1;
    else if (fire && p == 3) mrr = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < 4; l++) begin
      mv[l] = 0; mlen[l] = 0; mage[l] = 0; mmax[l] = 0; mhits[l] = 0;
    end
    mtok = 0; mlog = LD; mdiv = 0; mdrops = 0; mmis = 0; mrr = 0;
    rate = 0; depth = 20;
    rst_n = 0; in_valid = 0; in_tag = 0; in_len = 0; out_ready = 0;
    bulk_rate = 0; bulk_depth = 20;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 counters", int'(lane_hits != 0) + int'(lane_max_lat != 0) + int'(log_drops) + int'(miscls_count), 0);

    // R5: bulk parked while refill is zero, then released by tokens
    step(1, 2, 10, 1);
    repeat (3) step(0, 0, 0, 1);
    chk("R5 bulk held", int'(out_valid), 0);
    rate = 4;
    repeat (5) step(0, 0, 0, 1);

    // R4 R7 R3: load every lane while stalled, then drain
    step(1, 3, 5, 0);
    step(1, 2, 6, 0);
    step(1, 1, 7, 0);
    step(1, 0, 8, 0);
    step(1, 0, 9, 0);
    repeat (6) step(0, 0, 0, 1);

    // R2: undefined tag goes to log lane
    step(1, 5, 3, 1);
    repeat (3) step(0, 0, 0, 1);

    // R6: drain the log policer
    repeat (14) step(1, 3, 2, 1);
    repeat (4) step(0, 0, 0, 1);

    // random mix
    rate = 3; depth = 64;
    repeat (4000) begin
      int t, n;
      bit v, r;
      v = ($urandom_range(0, 2) != 0);
      t = $urandom_range(0, 7);
      n = $urandom_range(1, 40);
      r = ($urandom_range(0, 3) != 0);
      step(v, t, n, r);
    end
    repeat (40) step(0, 0, 0, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule